// File: doc/BRIEF.md
# Pipelined Byte-Write Word Memory

This block is the storage and data path behind a burst address sequencer. It holds 36-bit words, each split into four 9-bit lanes of eight data bits plus one parity bit. Each clock the sequencer presents a select, a word address and the write controls. A write can cover the whole word through a global write strobe, or chosen lanes through per-lane strobes that only count while a byte-write function strobe is low. Any selected cycle that writes no lane is a read.

Writes are captured in a write register on the rising edge and committed to the array on the next edge. A read issued in that gap takes the pending lanes from the write register. Read data passes through an output register, so a word shows on the data bus one clock after its address. An asynchronous active-low output enable gates the bus drivers combinationally. The drivers are also off whenever the output register holds no read result. The driver state is brought out as a separate enable for the pad ring.

Top module: `bwsram_core`

## Requirements
- R1: Lane k of a word occupies bits 9k+8 down to 9k, with its parity bit at 9k+8. A lane write changes exactly those nine bits.
- R2: With `wr_all_n` low in a selected cycle, all four lanes take `wdata`, whatever `lane_wr_fn_n` and `lane_n` are.
- R3: With `wr_all_n` high and `lane_wr_fn_n` low, each lane k whose `lane_n[k]` is 0 takes `wdata`. The other lanes keep their stored value.
- R4: A selected cycle with `wr_all_n` high and either `lane_wr_fn_n` high or `lane_n` all ones is a read. It leaves the array unchanged.
- R5: A read presented before a rising edge drives the addressed word on `dq` after that edge, with `dq_oe` high. This holds while `oe_n` is low.
- R6: `oe_n` high forces `dq_oe` low and `dq` to high impedance at once, with no clock edge needed. Returning `oe_n` low restores the held read data.
- R7: After reset, and after a cycle that was idle or a write, `dq_oe` is low even with `oe_n` low. Asserting reset drops `dq_oe` immediately.
- R8: A read in the cycle right after a write to the same address returns the newly written lanes, merged with the lanes the write left untouched.
- R9: A cycle with `sel` low writes nothing and returns no read data, whatever the write strobes are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| sel | input | 1 | Access valid in this cycle (from the sequencer) |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | Active-low global write of all lanes |
| lane_wr_fn_n | input | 1 | Active-low enable for the per-lane strobes |
| lane_n | input | 4 | Active-low per-lane write strobes; bit k selects lane k |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | output | 36 | Read data, high impedance when not driven |
| dq_oe | output | 1 | High while `dq` is driven |

## Verification
The main stimulus is a scripted run that mixes several kinds of access. Global writes are issued with the lane strobes inactive, to show that the global strobe overrides them. Partial lane writes use alternating lane patterns and a single top lane, to confirm lane boundaries and that parity bits are kept. Read-shaped writes, with the function strobe high or all lane strobes high, must leave stored data intact. Idle cycles that carry an active write strobe must do nothing. Back-to-back write-then-read pairs tell the bypass path apart from a plain array read. Directed steps toggle `oe_n` between edges and assert reset in mid-read, to separate the asynchronous gating from the registered pipeline.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Lanes written this cycle; zero means the cycle is a read.
  function automatic logic [LANES-1:0] lanes_written(input logic all_n,
                                                     input logic fn_n,
                                                     input logic [LANES-1:0] ln_n);
    if (!all_n)     return {LANES{1'b1}};
    else if (!fn_n) return ~ln_n;
    else            return '0;
  endfunction

  // Expand a lane mask to a bit mask.
  function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [WORD_W-1:0] b;
    for (int k = 0; k < LANES; k++) b[k*LANE_W +: LANE_W] = {LANE_W{m[k]}};
    return b;
  endfunction

  // Take the masked lanes from nw, the rest from old.
  function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] old,
                                                    input logic [WORD_W-1:0] nw,
                                                    input logic [LANES-1:0] m);
    logic [WORD_W-1:0] b;
    b = lane_bits(m);
    return (old & ~b) | (nw & b);
  endfunction
endpackage

// File: rtl/bwsram_wctl.sv
module bwsram_wctl
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_all_n,
  input  logic              lane_wr_fn_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [WORD_W-1:0] wdata,
  output logic              wr_vld_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [WORD_W-1:0] wr_data_q,
  output logic [LANES-1:0]  wr_mask_q,
  output logic              rd_en
);
  logic [LANES-1:0] cyc_mask;
  logic             wr_en;

  assign cyc_mask = lanes_written(wr_all_n, lane_wr_fn_n, lane_n);
  assign wr_en    = sel && (cyc_mask != '0);
  assign rd_en    = sel && (cyc_mask == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_mask_q <= '0;
    end else begin
      wr_vld_q <= wr_en;
      if (wr_en) begin
        wr_addr_q <= addr;
        wr_data_q <= wdata;
        wr_mask_q <= cyc_mask;
      end
    end
  end

  // R2
  gw_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_all_n) |=> (wr_vld_q && wr_mask_q == {LANES{1'b1}}));

  // R3
  lane_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_all_n && !lane_wr_fn_n && !(&lane_n)) |=> (wr_vld_q && wr_mask_q == ~$past(lane_n)));

  // R4
  read_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_all_n && (lane_wr_fn_n || (&lane_n))) |=> !wr_vld_q);
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld_q,
  input  logic [ADDR_W-1:0] wr_addr_q,
  input  logic [WORD_W-1:0] wr_data_q,
  input  logic [LANES-1:0]  wr_mask_q,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q,
  output logic              rd_vld_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] arr_word;
  logic [WORD_W-1:0] rd_word;
  logic              byp_hit;

  always_ff @(posedge clk) begin
    if (wr_vld_q) mem[wr_addr_q] <= merge_lanes(mem[wr_addr_q], wr_data_q, wr_mask_q);
  end

  assign arr_word = mem[rd_addr];
  assign byp_hit  = wr_vld_q && (wr_addr_q == rd_addr);
  assign rd_word  = byp_hit ? merge_lanes(arr_word, wr_data_q, wr_mask_q) : arr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      rd_vld_q <= rd_en;
      if (rd_en) rd_q <= rd_word;
    end
  end

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && byp_hit) |=>
      ((rd_q & lane_bits($past(wr_mask_q))) == ($past(wr_data_q) & lane_bits($past(wr_mask_q)))));

  // R5
  rd_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_q |-> $past(rd_en));
endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
  import bwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_all_n,
  input  logic              lane_wr_fn_n,
  input  logic [3:0]        lane_n,
  input  logic [35:0]       wdata,
  input  logic              oe_n,
  output logic [35:0]       dq,
  output logic              dq_oe
);
  logic              wr_vld_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [WORD_W-1:0] wr_data_q;
  logic [LANES-1:0]  wr_mask_q;
  logic              rd_en;
  logic [WORD_W-1:0] rd_q;
  logic              rd_vld_q;

  bwsram_wctl #(.ADDR_W(ADDR_W)) u_wctl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr),
    .wr_all_n(wr_all_n), .lane_wr_fn_n(lane_wr_fn_n), .lane_n(lane_n), .wdata(wdata),
    .wr_vld_q(wr_vld_q), .wr_addr_q(wr_addr_q), .wr_data_q(wr_data_q),
    .wr_mask_q(wr_mask_q), .rd_en(rd_en)
  );

  bwsram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_vld_q(wr_vld_q), .wr_addr_q(wr_addr_q), .wr_data_q(wr_data_q), .wr_mask_q(wr_mask_q),
    .rd_en(rd_en), .rd_addr(addr), .rd_q(rd_q), .rd_vld_q(rd_vld_q)
  );

  assign dq_oe = rd_vld_q && !oe_n;
  assign dq    = dq_oe ? rd_q : {WORD_W{1'bz}};

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!wr_vld_q && !rd_vld_q));

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R7
  no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || !rd_en) |=> !dq_oe);
endmodule

// File: tb/sim_bwsram_core.sv
module sim_bwsram_core;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic        sel;
    logic        all_n;
    logic        fn_n;
    logic [3:0]  ln_n;
    logic [5:0]  a;
    logic [35:0] wd;
    logic        oe;
    logic [3:0]  req;
  } vec_t;

  // sel all_n fn_n lane_n addr wdata oe_n req (req names the op being checked)
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0,           1'b0, 4'd7}, // R7 idle
    '{1'b1, 1'b0, 1'b0, 4'hF, 6'd1, 36'h9_ABCD_1234, 1'b0, 4'd2}, // R2 override
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0,           1'b0, 4'd8}, // R8
    '{1'b1, 1'b0, 1'b1, 4'h0, 6'd2, 36'h1_1111_1111, 1'b0, 4'd2}, // R2
    '{1'b1, 1'b1, 1'b0, 4'hA, 6'd2, 36'hF_FFFF_FFFF, 1'b0, 4'd3}, // R3 lanes 0,2
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd2, 36'h0,           1'b0, 4'd8}, // R8 merge
    '{1'b1, 1'b1, 1'b1, 4'h0, 6'd1, 36'h0,           1'b0, 4'd4}, // R4 fn high
    '{1'b1, 1'b1, 1'b0, 4'hF, 6'd1, 36'h0,           1'b0, 4'd4}, // R4 no lanes
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd1, 36'h0,           1'b0, 4'd9}, // R9
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0,           1'b0, 4'd9}, // R9 intact
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd2, 36'h0,           1'b0, 4'd6}, // R6
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0,           1'b1, 4'd5}, // R5
    '{1'b1, 1'b1, 1'b0, 4'h7, 6'd1, 36'h5_5555_5555, 1'b0, 4'd1}, // R1 lane 3
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0,           1'b0, 4'd1}, // R1
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd2, 36'h0,           1'b0, 4'd5}, // R5
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0,           1'b0, 4'd7}, // R7
    '{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0,           1'b0, 4'd5}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_all_n = 1'b1;
  logic        lane_wr_fn_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [35:0] dq;
  logic        dq_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] shadow [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  bwsram_core #(.ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr),
    .wr_all_n(wr_all_n), .lane_wr_fn_n(lane_wr_fn_n), .lane_n(lane_n), .wdata(wdata),
    .oe_n(oe_n), .dq(dq), .dq_oe(dq_oe)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver state and, when expected on, the data word.
  task automatic check(input string req, input logic exp_en, input logic [35:0] exp_d);
    n_chk++;
    if (dq_oe !== exp_en || (exp_en && dq !== exp_d)) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%0b dq=%h, expected dq_oe=%0b dq=%h", req, dq_oe, dq, exp_en, exp_d);
    end
  endtask

  task automatic drive(input vec_t v);
    sel = v.sel; addr = v.a; wr_all_n = v.all_n; lane_wr_fn_n = v.fn_n;
    lane_n = v.ln_n; wdata = v.wd; oe_n = v.oe;
  endtask

  // Bench model of one cycle: returns 1 and the word when it is a read.
  task automatic model(input vec_t v, output logic is_rd, output logic [35:0] d);
    logic [3:0] m;
    m = !v.all_n ? 4'hF : (!v.fn_n ? ~v.ln_n : 4'h0);
    is_rd = v.sel && (m == 4'h0);
    d = shadow[v.a];
    if (v.sel && m != 4'h0)
      for (int k = 0; k < 4; k++)
        if (m[k]) shadow[v.a][k*9 +: 9] = v.wd[k*9 +: 9];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic        prev_rd;
    logic [35:0] prev_d;
    vec_t        idle_v;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    idle_v = '{1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 4'd7};
    repeat (3) @(negedge clk);
    #1 check("R7", 1'b0, '0);           // reset state
    rst_n = 1'b1;
    prev_rd = 1'b0; prev_d = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      if (i > 0) check(rname(VEC[i-1].req), prev_rd && !VEC[i].oe, prev_d);
      model(VEC[i], prev_rd, prev_d);
    end
    @(negedge clk);
    drive(idle_v);
    #1 check(rname(VEC[NV-1].req), prev_rd, prev_d);

    // R6: asynchronous gating between edges
    @(negedge clk);
    drive('{1'b1, 1'b1, 1'b1, 4'hF, 6'd2, 36'h0, 1'b0, 4'd6});
    @(negedge clk);
    drive(idle_v);
    #1 check("R6", 1'b1, shadow[2]);
    oe_n = 1'b1;
    #1 check("R6", 1'b0, '0);
    oe_n = 1'b0;
    #1 check("R6", 1'b1, shadow[2]);

    // R7: reset drops the drivers mid-read
    @(negedge clk);
    drive('{1'b1, 1'b1, 1'b1, 4'hF, 6'd1, 36'h0, 1'b0, 4'd7});
    @(negedge clk);
    drive(idle_v);
    #1 check("R7", 1'b1, shadow[1]);
    rst_n = 1'b0;
    #1 check("R7", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R7", 1'b0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule